// File: doc/BRIEF.md
# Bidirectional Timer Counter Core

This block is a programmable timer counter that can count upward or downward. Its count changes only on a timer tick. The tick is a single-cycle enable in the system clock domain. It comes either from a synchronous source or from an alternate fast source. A clock-select field lets it through or stops it. On each accepted tick the count is cleared, stepped up or stepped down, depending on a clear request, the selected counting mode and an internal registered direction. Two combinational indications report when the count equals the programmable top value and when it is zero.

Software reaches the count through a CPU port at all times, including while the tick is stopped. A CPU write to the count takes precedence over any clear or step in the same cycle. The top register is also written through the CPU port.

A sticky overflow flag is set by a mode-specific event. Writing one to its clear input drops it. An interrupt request follows the flag when enabled.

Top module: `bidir_timer_core`

## Requirements
- R1: After reset the count is 0, the top register holds all ones (1023 at the default 10-bit width), the overflow flag is 0 and the interrupt output is 0.
- R2: A tick is accepted only when `clk_sel` is nonzero and the selected source pulses: `tick_fast` when `alt_clk_en` is 1, otherwise `tick_sync`. With `clk_sel` zero, or when only the unselected source pulses, the count does not change.
- R3: `cpu_wr_count` loads `cpu_wdata` into the count on the next clock edge. This holds whether or not a tick is present, and the load overrides a clear or step requested in the same cycle.
- R4: An accepted tick with `clr_req` high sets the count to 0 and the direction to up, and does not set the overflow flag.
- R5: Mode 0 (`mode_sel`=0) steps the count up by one per tick. When the count equals top, the tick wraps it to 0 and sets the overflow flag. A count above top keeps rising to all ones and then wraps to 0 without setting the flag.
- R6: Mode 1 (`mode_sel`=1) counts up until the count reaches top, then down until it reaches 0, then up again. The turn happens on the tick taken at top or at 0. A count above top steps downward.
- R7: In mode 1 the overflow flag is set by the tick that steps the count down from 1 to 0.
- R8: In mode 1 with top equal to 0, a count of 0 stays at 0 on every tick.
- R9: `at_top` is 1 exactly when the count equals the top register, and `at_bottom` is 1 exactly when the count is 0.
- R10: A pulse on `ovf_clr` clears the overflow flag on the next edge. If a set event occurs in the same cycle, the flag is set instead. With neither a set event nor a clear, the flag holds.
- R11: `irq` equals the overflow flag ANDed with `irq_en`.
- R12: `cpu_wr_top` loads `cpu_wdata` into the top register on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | CS_W | Tick source select; zero stops the counter |
| alt_clk_en | input | 1 | Selects the fast tick source instead of the synchronous one |
| tick_sync | input | 1 | Tick enable from the synchronous source |
| tick_fast | input | 1 | Tick enable from the alternate fast source |
| mode_sel | input | 1 | 0 = wrap-at-top up count, 1 = up/down count |
| clr_req | input | 1 | Clear the count on the next accepted tick |
| cpu_wdata | input | CNT_W | CPU write data for the count and top registers |
| cpu_wr_count | input | 1 | CPU write strobe for the count |
| cpu_wr_top | input | 1 | CPU write strobe for the top register |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| irq_en | input | 1 | Interrupt enable |
| count_q | output | CNT_W | Current count |
| top_q | output | CNT_W | Current top register |
| at_top | output | 1 | Count equals top |
| at_bottom | output | 1 | Count equals zero |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
Directed patterns run first, each chosen to separate two behaviours the RTL might confuse. A steady tick in mode 0 tells wrap-at-top apart from wrap at all ones, and a count written above top shows which wrap raises the flag. Mode 1 with a small top tells the turn at top and at zero apart from free running, and top equal to zero isolates the hold case. Same-cycle collisions come next: a write together with a clear and a tick, and a flag clear together with a flag set. These separate the priority orders. Pulsing only the unselected tick source, or pulsing with the select field at zero, tells gated ticks from raw ones. A long random phase then mixes modes, small tops, writes and clears, and every cycle is compared with a behavioural model.

// File: rtl/bidir_timer_pkg.sv
package bidir_timer_pkg;

  typedef enum logic {
    MODE_WRAP   = 1'b0,
    MODE_UPDOWN = 1'b1
  } cnt_mode_e;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } cnt_dir_e;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_CLEAR = 2'd2,
    ACT_STEP  = 2'd3
  } cnt_act_e;

endpackage

// File: rtl/bt_tick_select.sv
module bt_tick_select #(
  parameter int CS_W     = 4,
  parameter bit HAS_FAST = 1'b1
) (
  input  logic [CS_W-1:0] clk_sel,
  input  logic            alt_clk_en,
  input  logic            tick_sync,
  input  logic            tick_fast,
  output logic            src_running,
  output logic            tick
);

  logic picked;

  assign src_running = |clk_sel;

  generate
    if (HAS_FAST) begin : g_two_src
      assign picked = alt_clk_en ? tick_fast : tick_sync;
    end else begin : g_sync_only
      logic unused_fast;
      assign unused_fast = alt_clk_en ^ tick_fast;
      assign picked = tick_sync;
    end
  endgenerate

  assign tick = src_running & picked;

endmodule

// File: rtl/bt_step_ctrl.sv
module bt_step_ctrl
  import bidir_timer_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr_req,
  input  logic             cpu_wr,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] top,
  input  logic [CNT_W-1:0] wdata,
  output cnt_act_e         act,
  output logic [CNT_W-1:0] next_count,
  output logic             set_evt,
  output cnt_dir_e         dir_q
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  // Next value in wrap mode: reaching top folds back to zero.
  function automatic logic [CNT_W-1:0] wrap_next(input logic [CNT_W-1:0] c,
                                                 input logic [CNT_W-1:0] t);
    return (c == t) ? ZERO : c + ONE;
  endfunction

  // True when up/down mode must freeze (degenerate zero range).
  function automatic logic updown_frozen(input logic [CNT_W-1:0] c,
                                         input logic [CNT_W-1:0] t);
    return (t == ZERO) && (c == ZERO);
  endfunction

  // Direction taken on this tick in up/down mode.
  function automatic cnt_dir_e updown_dir(input logic [CNT_W-1:0] c,
                                          input logic [CNT_W-1:0] t,
                                          input cnt_dir_e         d);
    if (updown_frozen(c, t)) return d;
    if (c >= t)              return DIR_DOWN;
    if (c == ZERO)           return DIR_UP;
    return d;
  endfunction

  function automatic logic [CNT_W-1:0] updown_next(input logic [CNT_W-1:0] c,
                                                   input logic [CNT_W-1:0] t,
                                                   input cnt_dir_e         d);
    if (updown_frozen(c, t)) return c;
    return (d == DIR_DOWN) ? c - ONE : c + ONE;
  endfunction

  cnt_dir_e eff_dir;
  cnt_dir_e dir_nxt;
  logic     wrap_hit;
  logic     bottom_hit;

  always_comb begin
    if (cpu_wr)                act = ACT_LOAD;
    else if (tick && clr_req)  act = ACT_CLEAR;
    else if (tick)             act = ACT_STEP;
    else                       act = ACT_HOLD;
  end

  assign eff_dir    = (mode == MODE_WRAP) ? DIR_UP : updown_dir(count, top, dir_q);
  assign wrap_hit   = (mode == MODE_WRAP) && (count == top);
  assign bottom_hit = (mode == MODE_UPDOWN) && !updown_frozen(count, top)
                      && (eff_dir == DIR_DOWN) && (count == ONE);

  always_comb begin
    unique case (act)
      ACT_LOAD:  next_count = wdata;
      ACT_CLEAR: next_count = ZERO;
      ACT_STEP:  next_count = (mode == MODE_WRAP) ? wrap_next(count, top)
                                                  : updown_next(count, top, eff_dir);
      default:   next_count = count;
    endcase
  end

  always_comb begin
    unique case (act)
      ACT_CLEAR: dir_nxt = DIR_UP;
      ACT_STEP:  dir_nxt = eff_dir;
      default:   dir_nxt = dir_q;
    endcase
  end

  assign set_evt = (act == ACT_STEP) && (wrap_hit || bottom_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) dir_q <= DIR_UP;
    else        dir_q <= dir_nxt;
  end

  AST_TURN_DOWN_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_STEP && mode == MODE_UPDOWN && top != ZERO && count >= top)
    |=> (dir_q == DIR_DOWN)); // R6

  AST_TURN_UP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_STEP && mode == MODE_UPDOWN && top != ZERO && count == ZERO)
    |=> (dir_q == DIR_UP)); // R6

  AST_CLEAR_SETS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_CLEAR) |=> (dir_q == DIR_UP)); // R4

endmodule

// File: rtl/bt_ovf_flag.sv
module bt_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_wr,
  output logic flag_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_wr)  flag_q <= 1'b0;
  end

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q); // R10

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !set_evt) |=> !flag_q); // R10

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && !set_evt) |=> $stable(flag_q)); // R10

endmodule

// File: rtl/bidir_timer_core.sv
module bidir_timer_core
  import bidir_timer_pkg::*;
#(
  parameter int               CNT_W    = 10,
  parameter int               CS_W     = 4,
  parameter bit               HAS_FAST = 1'b1,
  parameter logic [CNT_W-1:0] TOP_INIT = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CS_W-1:0]  clk_sel,
  input  logic             alt_clk_en,
  input  logic             tick_sync,
  input  logic             tick_fast,
  input  logic             mode_sel,
  input  logic             clr_req,
  input  logic [CNT_W-1:0] cpu_wdata,
  input  logic             cpu_wr_count,
  input  logic             cpu_wr_top,
  input  logic             ovf_clr,
  input  logic             irq_en,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] top_q,
  output logic             at_top,
  output logic             at_bottom,
  output logic             ovf_flag,
  output logic             irq
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic             tick;
  logic             src_running;
  cnt_mode_e        mode;
  cnt_act_e         act;
  cnt_dir_e         dir_q;
  logic [CNT_W-1:0] next_count;
  logic             set_evt;

  assign mode = cnt_mode_e'(mode_sel);

  bt_tick_select #(
    .CS_W     (CS_W),
    .HAS_FAST (HAS_FAST)
  ) u_tick (
    .clk_sel     (clk_sel),
    .alt_clk_en  (alt_clk_en),
    .tick_sync   (tick_sync),
    .tick_fast   (tick_fast),
    .src_running (src_running),
    .tick        (tick)
  );

  bt_step_ctrl #(
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .clr_req    (clr_req),
    .cpu_wr     (cpu_wr_count),
    .mode       (mode),
    .count      (count_q),
    .top        (top_q),
    .wdata      (cpu_wdata),
    .act        (act),
    .next_count (next_count),
    .set_evt    (set_evt),
    .dir_q      (dir_q)
  );

  bt_ovf_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (set_evt),
    .clr_wr  (ovf_clr),
    .flag_q  (ovf_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= ZERO;
      top_q   <= TOP_INIT;
    end else begin
      count_q <= next_count;
      if (cpu_wr_top) top_q <= cpu_wdata;
    end
  end

  assign at_top    = (count_q == top_q);
  assign at_bottom = (count_q == ZERO);
  assign irq       = ovf_flag & irq_en;

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_running && !cpu_wr_count) |=> $stable(count_q)); // R2

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_count |=> (count_q == $past(cpu_wdata))); // R3

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clr_req && !cpu_wr_count) |=> (count_q == ZERO && !$rose(ovf_flag))); // R4

  AST_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr_req && !cpu_wr_count && mode == MODE_WRAP && count_q != top_q)
    |=> (count_q == $past(count_q) + ONE)); // R5

  AST_BOTTOM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr_req && !cpu_wr_count && mode == MODE_UPDOWN
     && count_q == ONE && (dir_q == DIR_DOWN || count_q >= top_q))
    |=> (ovf_flag && count_q == ZERO)); // R7

  AST_ZERO_TOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_UPDOWN && top_q == ZERO && count_q == ZERO && !cpu_wr_count)
    |=> (count_q == ZERO)); // R8

  AST_TOP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_top |=> (top_q == $past(cpu_wdata))); // R12

endmodule

// File: tb/tb_bidir_timer_core.sv
`timescale 1ns/1ps
module tb_bidir_timer_core;

  localparam int CNT_W = 10;
  localparam int CS_W  = 4;
  localparam int MAXV  = (1 << CNT_W) - 1;
  localparam int WATCHDOG = 100000;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CS_W-1:0]  clk_sel;
  logic             alt_clk_en, tick_sync, tick_fast, mode_sel, clr_req;
  logic [CNT_W-1:0] cpu_wdata;
  logic             cpu_wr_count, cpu_wr_top, ovf_clr, irq_en;
  logic [CNT_W-1:0] count_q, top_q;
  logic             at_top, at_bottom, ovf_flag, irq;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  // behavioural reference state
  int m_cnt, m_top, m_flag;
  bit m_down;

  always #2.5 clk = ~clk;

  bidir_timer_core #(.CNT_W(CNT_W), .CS_W(CS_W)) dut (
    .clk, .rst_n, .clk_sel, .alt_clk_en, .tick_sync, .tick_fast, .mode_sel,
    .clr_req, .cpu_wdata, .cpu_wr_count, .cpu_wr_top, .ovf_clr, .irq_en,
    .count_q, .top_q, .at_top, .at_bottom, .ovf_flag, .irq
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Reference model: one update per rising edge from the inputs held since the falling edge.
  always @(posedge clk) begin
    bit tk, set;
    tk  = (clk_sel != 0) && (alt_clk_en ? tick_fast : tick_sync);
    set = 1'b0;
    if (!rst_n) begin
      m_cnt = 0; m_top = MAXV; m_flag = 0; m_down = 1'b0;
    end else begin
      if (cpu_wr_count) begin
        m_cnt = cpu_wdata;
      end else if (tk && clr_req) begin
        m_cnt = 0; m_down = 1'b0;
      end else if (tk && !mode_sel) begin
        m_down = 1'b0;
        if (m_cnt == m_top) begin m_cnt = 0; set = 1'b1; end
        else m_cnt = (m_cnt + 1) % (MAXV + 1);
      end else if (tk) begin
        if (m_top == 0 && m_cnt == 0) begin
          // frozen
        end else begin
          if (m_cnt >= m_top) m_down = 1'b1;
          else if (m_cnt == 0) m_down = 1'b0;
          if (m_down) begin
            if (m_cnt == 1) set = 1'b1;
            m_cnt = m_cnt - 1;
          end else begin
            m_cnt = m_cnt + 1;
          end
        end
      end
      if (set) m_flag = 1;
      else if (ovf_clr) m_flag = 0;
      if (cpu_wr_top) m_top = cpu_wdata;
    end
  end

  // Per-cycle comparison, sampled after the edge has settled.
  always begin
    @(posedge clk);
    #1;
    cycles++;
    if (rst_n === 1'b1 && !done) begin
      chk("R3 R5 R6 count", int'(count_q), m_cnt);
      chk("R12 top", int'(top_q), m_top);
      chk("R9 at_top", int'(at_top), int'(m_cnt == m_top));
      chk("R9 at_bottom", int'(at_bottom), int'(m_cnt == 0));
      chk("R10 flag", int'(ovf_flag), m_flag);
      chk("R11 irq", int'(irq), m_flag & int'(irq_en));
    end
    if (cycles > WATCHDOG && !done) begin
      n_fails++;
      $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; clk_sel = '0; alt_clk_en = 0; tick_sync = 0; tick_fast = 0;
    mode_sel = 0; clr_req = 0; cpu_wdata = '0; cpu_wr_count = 0; cpu_wr_top = 0;
    ovf_clr = 0; irq_en = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 count", int'(count_q), 0);
    chk("R1 top", int'(top_q), MAXV);
    chk("R1 flag", int'(ovf_flag), 0);
    chk("R1 irq", int'(irq), 0);

    // R2: ticks with the select field at zero are dropped
    tick_sync = 1; cyc(4);
    chk("R2 stopped", int'(count_q), 0);

    // R12: program top = 5
    cpu_wdata = 10'd5; cpu_wr_top = 1; cyc(1); cpu_wr_top = 0;
    chk("R12 top load", int'(top_q), 5);

    // R5: wrap mode, steady tick
    clk_sel = 4'd1; cyc(5);
    chk("R5 count at top", int'(count_q), 5);
    chk("R9 at_top", int'(at_top), 1);
    cyc(1);
    chk("R5 wrap", int'(count_q), 0);
    chk("R5 wrap flag", int'(ovf_flag), 1);
    chk("R9 at_bottom", int'(at_bottom), 1);

    // R11: interrupt follows the enable
    chk("R11 masked", int'(irq), 0);
    irq_en = 1; #1;
    chk("R11 enabled", int'(irq), 1);

    // R10: clear, then set and clear together
    tick_sync = 0; ovf_clr = 1; cyc(1); ovf_clr = 0;
    chk("R10 clear", int'(ovf_flag), 0);
    cpu_wdata = 10'd5; cpu_wr_count = 1; cyc(1); cpu_wr_count = 0;
    chk("R3 load idle", int'(count_q), 5);
    tick_sync = 1; ovf_clr = 1; cyc(1); tick_sync = 0; ovf_clr = 0;
    chk("R10 set beats clear", int'(ovf_flag), 1);
    chk("R5 wrap again", int'(count_q), 0);

    // R3: write beats clear and tick
    tick_sync = 1; clr_req = 1; cpu_wdata = 10'd3; cpu_wr_count = 1; cyc(1);
    tick_sync = 0; clr_req = 0; cpu_wr_count = 0;
    chk("R3 write wins", int'(count_q), 3);
    clk_sel = '0; cpu_wdata = 10'd7; cpu_wr_count = 1; cyc(1); cpu_wr_count = 0;
    chk("R3 write while stopped", int'(count_q), 7);
    clk_sel = 4'd1;

    // R4: clear on tick
    tick_sync = 1; clr_req = 1; cyc(1); tick_sync = 0; clr_req = 0;
    chk("R4 clear", int'(count_q), 0);

    // R5: above top wraps at all ones with no flag
    ovf_clr = 1; cyc(1); ovf_clr = 0;
    cpu_wdata = 10'(MAXV - 1); cpu_wr_count = 1; cyc(1); cpu_wr_count = 0;
    tick_sync = 1; cyc(1);
    chk("R5 above top", int'(count_q), MAXV);
    cyc(1); tick_sync = 0;
    chk("R5 natural wrap", int'(count_q), 0);
    chk("R5 no flag", int'(ovf_flag), 0);

    // R2: only the selected source counts
    alt_clk_en = 1; tick_sync = 1; tick_fast = 0; cyc(3);
    chk("R2 unselected source", int'(count_q), 0);
    tick_fast = 1; cyc(2); tick_fast = 0; tick_sync = 0; alt_clk_en = 0;
    chk("R2 fast source", int'(count_q), 2);

    // R6/R7: up/down with top = 3
    cpu_wdata = 10'd3; cpu_wr_top = 1; cyc(1); cpu_wr_top = 0;
    cpu_wdata = 10'd0; cpu_wr_count = 1; cyc(1); cpu_wr_count = 0;
    mode_sel = 1; tick_sync = 1; cyc(3);
    chk("R6 reach top", int'(count_q), 3);
    cyc(2);
    chk("R6 counting down", int'(count_q), 1);
    chk("R7 no flag yet", int'(ovf_flag), 0);
    cyc(1);
    chk("R7 bottom", int'(count_q), 0);
    chk("R7 flag", int'(ovf_flag), 1);
    cyc(1); tick_sync = 0;
    chk("R6 turn up", int'(count_q), 1);

    // R8: zero top freezes at zero
    ovf_clr = 1; cyc(1); ovf_clr = 0;
    cpu_wdata = 10'd0; cpu_wr_top = 1; cyc(1); cpu_wr_top = 0;
    cpu_wdata = 10'd2; cpu_wr_count = 1; cyc(1); cpu_wr_count = 0;
    tick_sync = 1; cyc(5); tick_sync = 0;
    chk("R8 hold zero", int'(count_q), 0);
    chk("R7 flag from above", int'(ovf_flag), 1);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (i % 200 == 0) mode_sel = 1'($urandom_range(0, 1));
      clk_sel      = ($urandom_range(0, 7) == 0) ? '0 : CS_W'($urandom_range(1, 15));
      alt_clk_en   = ($urandom_range(0, 9) == 0);
      tick_sync    = 1'($urandom_range(0, 1));
      tick_fast    = 1'($urandom_range(0, 1));
      clr_req      = ($urandom_range(0, 39) == 0);
      ovf_clr      = ($urandom_range(0, 15) == 0);
      irq_en       = 1'($urandom_range(0, 1));
      cpu_wr_top   = ($urandom_range(0, 63) == 0);
      cpu_wr_count = ($urandom_range(0, 79) == 0);
      cpu_wdata    = ($urandom_range(0, 9) == 0) ? 10'($urandom_range(MAXV - 3, MAXV))
                                                 : 10'($urandom_range(0, 12));
    end
    @(negedge clk);
    clk_sel = '0; tick_sync = 0; tick_fast = 0; clr_req = 0; ovf_clr = 0;
    cpu_wr_top = 0; cpu_wr_count = 0;
    cyc(3);
    finish_run();
  end

endmodule